// File: doc/BRIEF.md
# Queued Memory Copy Engine with Loopback

This block is a register-programmed DMA engine. Software places a source address, a destination address and two word counts in registers. Writing the destination count commits all four values as one command into a small in-order queue. The engine takes commands from the head of the queue one at a time. It fetches source words over a single-word memory request/acknowledge port in bounded bursts. In stream mode the words of each burst leave on a valid/ready configuration stream. In loopback mode they are written back to memory at the destination address.

Each burst first fills an internal staging buffer with up to `BURST_BYTES/4` words, and only then drains them. A command leaves the queue once no further burst can move data. At that point two completion flags are set in an interrupt status register. That register is cleared by writing ones. A mask register gates the flags onto a single interrupt line.

Back-pressure rules: `cfg_valid` stays high and `cfg_data` stays unchanged until a cycle in which `cfg_ready` is high, and that cycle transfers the word. `mem_req` stays high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until `mem_ack` is high for one cycle. That cycle completes one word, and for a read `mem_rdata` must be valid in that same cycle. Register reads are combinational on `reg_addr`. A write takes effect at the clock edge where `reg_we` is high.

Top module: `dmaq_top`

## Requirements
- R1: A write to offset 0x24 pushes a command made of the current contents of 0x18 (source address), 0x1C (destination address) and 0x20 (source words), together with the written value as destination words. Status register 0x14 reads bit 30 = queue empty and bit 31 = queue full. After reset bit 30 is 1 and bit 31 is 0. The queue holds QDEPTH commands, and the command being executed counts as one of them.
- R2: Every memory address the engine issues for a command has its two low bits forced to zero, for both source and destination.
- R3: A push while the queue is full sets interrupt status bit 14 and discards the command, so the command is never executed.
- R4: In stream mode (0x80 bit 4 = 0) the engine reads source words at consecutive addresses, rising by 4. Each word is sent on the configuration stream in the order it was read, and no memory write is issued.
- R5: A burst moves N = min(BURST_BYTES/4, remaining source words) words, and in loopback N is also capped by the remaining destination words. All N reads of a burst complete before the first output of that burst.
- R6: In loopback mode (0x80 bit 4 = 1) each word read is written to the destination address, and the destination address rises by 4 per word. The mode is taken from bit 4 when a command starts.
- R7: A command is retired when its next burst size would be zero. In loopback this happens after min(source, destination) words. In stream mode the destination count is ignored.
- R8: Retiring a command sets interrupt status bits 13 and 12 and removes the command from the queue head. A command with zero source words is retired without any memory access.
- R9: Writing to 0x0C clears each interrupt status bit that is written as 1 and leaves the others unchanged. A flag being set in the same cycle wins over the clear.
- R10: The mask at 0x10 resets to all ones. `irq` is high whenever some interrupt status bit is 1 and its mask bit is 0.
- R11: Commands execute strictly in push order. While the queue is empty, neither `mem_req` nor `cfg_valid` is asserted.
- R12: Once `cfg_valid` is high without `cfg_ready`, `cfg_data` is held. Once `mem_req` is high without `mem_ack`, the request fields are held.
- R13: The length registers 0x20 and 0x24 keep only bits 26:0 and read back zero above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the pending word |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | 32 | Configuration word |
| cfg_ready | input | 1 | Consumer accepts the word |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the block with QDEPTH = 4 and BURST_BYTES = 32, so each burst holds eight words. With that setting, commands of ten to twenty words split into several bursts, and the interleaving of read blocks with stream or write blocks can be seen. A full queue is reached with four commands held behind a stalled memory, which brings the overflow flag and the discard within reach. Lengths of up to twenty words, mismatched loopback counts and zero-length commands cover the retire rule. Random acknowledge and ready stalls exercise the hold rules.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 27;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFF_INT_STS  = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_INT_MASK = 8'h10;
  localparam logic [REG_AW-1:0] OFF_STATUS   = 8'h14;
  localparam logic [REG_AW-1:0] OFF_SRC      = 8'h18;
  localparam logic [REG_AW-1:0] OFF_DST      = 8'h1C;
  localparam logic [REG_AW-1:0] OFF_SRC_LEN  = 8'h20;
  localparam logic [REG_AW-1:0] OFF_DST_LEN  = 8'h24;
  localparam logic [REG_AW-1:0] OFF_MISC     = 8'h80;

  localparam int BIT_PDONE  = 12;
  localparam int BIT_DONE   = 13;
  localparam int BIT_QOVF   = 14;
  localparam int BIT_QEMPTY = 30;
  localparam int BIT_QFULL  = 31;
  localparam int BIT_LOOP   = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic [LEN_W-1:0]  src_len;
    logic [LEN_W-1:0]  dst_len;
  } dmaq_cmd_t;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_PLAN,
    ENG_READ,
    ENG_WRITE,
    ENG_STREAM
  } dmaq_state_e;
endpackage

// File: rtl/dmaq_cmd_queue.sv
module dmaq_cmd_queue
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  dmaq_cmd_t        push_cmd,
  input  logic             pop,
  output dmaq_cmd_t        head,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  dmaq_cmd_t slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slots[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        slots[wr_ptr] <= push_cmd;
        wr_ptr        <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
    end
  end
endmodule

// File: rtl/dmaq_regs.sv
module dmaq_regs
  import dmaq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              retire,
  input  logic              q_full,
  input  logic              q_empty,
  output logic              push,
  output dmaq_cmd_t         push_cmd,
  output logic              loop_en,
  output logic              irq
);
  localparam logic [DATA_W-1:0] STS_IMPL =
    (DATA_W'(1) << BIT_PDONE) | (DATA_W'(1) << BIT_DONE) | (DATA_W'(1) << BIT_QOVF);

  logic [ADDR_W-1:0] src_r, dst_r;
  logic [LEN_W-1:0]  slen_r, dlen_r;
  logic [DATA_W-1:0] mask_r, sts_r, sts_nxt;
  logic              loop_r, overflow;

  assign push     = we && (addr == OFF_DST_LEN);
  assign overflow = push && q_full;
  assign loop_en  = loop_r;
  assign irq      = |(sts_r & ~mask_r);

  always_comb begin
    push_cmd.src_addr = {src_r[ADDR_W-1:2], 2'b00};
    push_cmd.dst_addr = {dst_r[ADDR_W-1:2], 2'b00};
    push_cmd.src_len  = slen_r;
    push_cmd.dst_len  = wdata[LEN_W-1:0];
  end

  always_comb begin
    sts_nxt = sts_r;
    if (we && addr == OFF_INT_STS) sts_nxt = sts_r & ~wdata;
    if (retire) begin
      sts_nxt[BIT_DONE]  = 1'b1;
      sts_nxt[BIT_PDONE] = 1'b1;
    end
    if (overflow) sts_nxt[BIT_QOVF] = 1'b1;
    sts_nxt = sts_nxt & STS_IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_r  <= '0;
      dst_r  <= '0;
      slen_r <= '0;
      dlen_r <= '0;
      loop_r <= 1'b0;
      mask_r <= '1;
      sts_r  <= '0;
    end else begin
      sts_r <= sts_nxt;
      if (we) begin
        case (addr)
          OFF_SRC:      src_r  <= wdata;
          OFF_DST:      dst_r  <= wdata;
          OFF_SRC_LEN:  slen_r <= wdata[LEN_W-1:0];
          OFF_DST_LEN:  dlen_r <= wdata[LEN_W-1:0];
          OFF_INT_MASK: mask_r <= wdata;
          OFF_MISC:     loop_r <= wdata[BIT_LOOP];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFF_INT_STS:  rdata = sts_r;
      OFF_INT_MASK: rdata = mask_r;
      OFF_STATUS: begin
        rdata[BIT_QFULL]  = q_full;
        rdata[BIT_QEMPTY] = q_empty;
      end
      OFF_SRC:      rdata = src_r;
      OFF_DST:      rdata = dst_r;
      OFF_SRC_LEN:  rdata = DATA_W'(slen_r);
      OFF_DST_LEN:  rdata = DATA_W'(dlen_r);
      OFF_MISC:     rdata[BIT_LOOP] = loop_r;
      default: ;
    endcase
  end
endmodule

// File: rtl/dmaq_engine.sv
module dmaq_engine
  import dmaq_pkg::*;
#(
  parameter int BURST_WORDS = 256,
  localparam int CNT_W = $clog2(BURST_WORDS + 1),
  localparam int IDX_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  dmaq_cmd_t         head,
  input  logic              loop_en,
  output logic              retire,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cfg_valid,
  output logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_ready
);
  dmaq_state_e       state;
  logic [ADDR_W-1:0] src_a, dst_a;
  logic [LEN_W-1:0]  src_rem, dst_rem, lim;
  logic              loop_q;
  logic [CNT_W-1:0]  bw, idx;
  logic              last;
  logic [DATA_W-1:0] stage_mem [BURST_WORDS];
  logic [DATA_W-1:0] stage_out;

  always_comb begin
    lim = src_rem;
    if (loop_q && (dst_rem < src_rem)) lim = dst_rem;
    if (lim > LEN_W'(BURST_WORDS)) lim = LEN_W'(BURST_WORDS);
  end

  assign last      = (idx == bw - CNT_W'(1));
  assign stage_out = stage_mem[idx[IDX_W-1:0]];
  assign retire    = (state == ENG_PLAN) && (lim == '0);
  assign mem_req   = (state == ENG_READ) || (state == ENG_WRITE);
  assign mem_we    = (state == ENG_WRITE);
  assign mem_addr  = (state == ENG_WRITE) ? dst_a : src_a;
  assign mem_wdata = stage_out;
  assign cfg_valid = (state == ENG_STREAM);
  assign cfg_data  = stage_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      src_a   <= '0;
      dst_a   <= '0;
      src_rem <= '0;
      dst_rem <= '0;
      loop_q  <= 1'b0;
      bw      <= '0;
      idx     <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (!q_empty) begin
          src_a   <= head.src_addr;
          dst_a   <= head.dst_addr;
          src_rem <= head.src_len;
          dst_rem <= head.dst_len;
          loop_q  <= loop_en;
          state   <= ENG_PLAN;
        end
        ENG_PLAN: begin
          if (lim == '0) begin
            state <= ENG_IDLE;
          end else begin
            bw    <= lim[CNT_W-1:0];
            idx   <= '0;
            state <= ENG_READ;
          end
        end
        ENG_READ: if (mem_ack) begin
          stage_mem[idx[IDX_W-1:0]] <= mem_rdata;
          src_a   <= src_a + ADDR_W'(4);
          src_rem <= src_rem - LEN_W'(1);
          if (last) begin
            idx   <= '0;
            state <= loop_q ? ENG_WRITE : ENG_STREAM;
          end else begin
            idx <= idx + CNT_W'(1);
          end
        end
        ENG_WRITE: if (mem_ack) begin
          dst_a   <= dst_a + ADDR_W'(4);
          dst_rem <= dst_rem - LEN_W'(1);
          if (last) state <= ENG_PLAN;
          else      idx   <= idx + CNT_W'(1);
        end
        ENG_STREAM: if (cfg_ready) begin
          if (last) state <= ENG_PLAN;
          else      idx   <= idx + CNT_W'(1);
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmaq_top.sv
module dmaq_top
  import dmaq_pkg::*;
#(
  parameter int QDEPTH      = 4,
  parameter int BURST_BYTES = 1024,
  localparam int BURST_WORDS = BURST_BYTES / 4,
  localparam int QCNT_W      = $clog2(QDEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        cfg_valid,
  output logic [31:0] cfg_data,
  input  logic        cfg_ready,
  output logic        irq
);
  dmaq_cmd_t         push_cmd, head;
  logic              q_push, q_pop, q_full, q_empty, loop_en;
  logic [QCNT_W-1:0] q_count;
  logic [7:0]        q_level;

  assign q_level = 8'(q_count);

  dmaq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .retire(q_pop), .q_full(q_full), .q_empty(q_empty),
    .push(q_push), .push_cmd(push_cmd), .loop_en(loop_en), .irq(irq)
  );

  dmaq_cmd_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_cmd(push_cmd), .pop(q_pop),
    .head(head), .full(q_full), .empty(q_empty), .count(q_count)
  );

  dmaq_engine #(.BURST_WORDS(BURST_WORDS)) u_engine (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .head(head), .loop_en(loop_en),
    .retire(q_pop), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready)
  );
endmodule

// File: rtl/dmaq_checker.sv
module dmaq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [31:0] cfg_data,
  input logic        q_empty,
  input logic        q_full,
  input logic        q_push,
  input logic        q_pop,
  input logic [7:0]  q_level
);
  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data));

  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !mem_req && !cfg_valid);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_push && q_full && !q_pop |=> q_level == $past(q_level));

  p_retire_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop && !q_push |=> q_level == $past(q_level) - 8'd1);

  p_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q_full, q_empty}));
endmodule

bind dmaq_top dmaq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready), .cfg_data(cfg_data), .q_empty(q_empty), .q_full(q_full),
  .q_push(q_push), .q_pop(q_pop), .q_level(q_level)
);

// File: tb/test_dmaq_top.sv
`timescale 1ns/1ps
module test_dmaq_top;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, cfg_valid, irq;
  logic [31:0] mem_addr, mem_wdata, cfg_data;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic cfg_ready = 1'b0;
  logic ack_en = 1'b1;

  int checks = 0;
  int failures = 0;
  logic [33:0] op_log [$];
  logic [33:0] exp_log [$];
  logic [63:0] exp_wr [$];
  logic [31:0] wr_mem [logic [31:0]];

  always #4 clk = ~clk;

  dmaq_top #(.QDEPTH(4), .BURST_BYTES(BW * 4)) i_dmaq_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cfg_valid(cfg_valid),
    .cfg_data(cfg_data), .cfg_ready(cfg_ready), .irq(irq)
  );

  function automatic logic [31:0] memval(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && ack_en && ($urandom % 4 != 0)) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          wr_mem[mem_addr] = mem_wdata;
          op_log.push_back({2'd1, mem_addr});
        end else begin
          mem_rdata = memval(mem_addr);
          op_log.push_back({2'd0, mem_addr});
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  // stream sink with hold check
  initial begin
    logic stalled;
    logic [31:0] held;
    stalled = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      if (stalled) chk("R12 stream hold", {31'd0, cfg_valid, cfg_data}, {31'd0, 1'b1, held});
      cfg_ready = ($urandom % 3 != 0);
      if (cfg_valid && cfg_ready) op_log.push_back({2'd2, cfg_data});
      stalled = cfg_valid && !cfg_ready;
      held = cfg_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic build_exp(input logic [31:0] src, input logic [31:0] dst,
                           input int sl, input int dl, input bit loop);
    logic [31:0] sa, da;
    int s, d, n;
    sa = {src[31:2], 2'b00};
    da = {dst[31:2], 2'b00};
    s = sl; d = dl;
    forever begin
      n = s;
      if (loop && d < n) n = d;
      if (n > BW) n = BW;
      if (n == 0) break;
      for (int i = 0; i < n; i++) exp_log.push_back({2'd0, sa + 32'(4 * i)});
      for (int i = 0; i < n; i++) begin
        if (loop) begin
          exp_log.push_back({2'd1, da + 32'(4 * i)});
          exp_wr.push_back({da + 32'(4 * i), memval(sa + 32'(4 * i))});
        end else begin
          exp_log.push_back({2'd2, memval(sa + 32'(4 * i))});
        end
      end
      sa += 32'(4 * n);
      s -= n;
      if (loop) begin
        da += 32'(4 * n);
        d -= n;
      end
    end
  endtask

  task automatic push_cmd(input logic [31:0] src, input logic [31:0] dst, input int sl, input int dl);
    reg_write(8'h18, src);
    reg_write(8'h1C, dst);
    reg_write(8'h20, 32'(sl));
    reg_write(8'h24, 32'(dl));
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    st = '0;
    repeat (3) @(negedge clk);
    do reg_read(8'h14, st); while (!st[30]);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_log(input string req);
    int bad;
    logic [33:0] a, e;
    bad = -1;
    a = '0; e = '0;
    if (op_log.size() != exp_log.size()) begin
      chk({req, " op count"}, 64'(op_log.size()), 64'(exp_log.size()));
    end else begin
      for (int i = 0; i < op_log.size(); i++)
        if (bad < 0 && op_log[i] !== exp_log[i]) begin
          bad = i; a = op_log[i]; e = exp_log[i];
        end
      chk({req, " op sequence"}, 64'(a), 64'(e));
    end
    foreach (exp_wr[i]) begin
      logic [31:0] got;
      got = wr_mem.exists(exp_wr[i][63:32]) ? wr_mem[exp_wr[i][63:32]] : 32'hDEAD_BEEF;
      chk({req, " loopback data"}, 64'(got), 64'(exp_wr[i][31:0]));
    end
    op_log.delete();
    exp_log.delete();
    exp_wr.delete();
  endtask

  task automatic run_cmd(input string req, input logic [31:0] src, input logic [31:0] dst,
                         input int sl, input int dl, input bit loop);
    logic [31:0] st;
    reg_write(8'h80, loop ? 32'h10 : 32'h0);
    build_exp(src, dst, sl, dl, loop);
    push_cmd(src, dst, sl, dl);
    wait_idle();
    check_log(req);
    reg_read(8'h0C, st);
    chk({req, " R8 done flags"}, 64'(st[13:12]), 64'd3);
    reg_write(8'h0C, 32'hFFFF_FFFF);
  endtask

  initial begin
    logic [31:0] v;
    int base;
    void'($urandom(32'd2024));
    v = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    reg_read(8'h14, v);
    chk("R1 empty at reset", 64'(v[31:30]), 64'b01);
    reg_read(8'h10, v);
    chk("R10 mask reset", 64'(v), 64'hFFFF_FFFF);
    reg_read(8'h0C, v);
    chk("R9 status reset", 64'(v), 64'd0);
    chk("R10 irq reset", 64'(irq), 64'd0);

    // length register width
    reg_write(8'h20, 32'hFFFF_FFFF);
    reg_read(8'h20, v);
    chk("R13 src length bits", 64'(v), 64'h07FF_FFFF);

    // basic stream with unaligned source
    reg_write(8'h80, 32'h0);
    build_exp(32'h1003, 32'h0, 5, 0, 0);
    push_cmd(32'h1003, 32'h0, 5, 0);
    wait_idle();
    check_log("R4 R2 stream");
    reg_read(8'h0C, v);
    chk("R8 done bits", 64'(v), 64'h3000);
    chk("R10 masked irq", 64'(irq), 64'd0);
    reg_write(8'h10, ~(32'h1 << 13));
    #1 chk("R10 unmasked irq", 64'(irq), 64'd1);
    reg_write(8'h0C, 32'h1 << 12);
    reg_read(8'h0C, v);
    chk("R9 w1c partial", 64'(v), 64'h2000);
    chk("R10 irq held", 64'(irq), 64'd1);
    reg_write(8'h0C, 32'h1 << 13);
    reg_read(8'h0C, v);
    chk("R9 w1c all", 64'(v), 64'd0);
    chk("R10 irq cleared", 64'(irq), 64'd0);
    reg_write(8'h10, 32'hFFFF_FFFF);

    // multi-burst stream, dst length ignored
    run_cmd("R5 R7 stream bursts", 32'h2000, 32'h9000, 20, 3, 0);
    // loopback multi-burst with unaligned destination
    run_cmd("R6 R5 R2 loopback", 32'h3000, 32'h8001, 10, 10, 1);
    // mismatched loopback lengths
    run_cmd("R7 loopback dst short", 32'h3400, 32'h8800, 12, 3, 1);
    run_cmd("R7 loopback src short", 32'h3800, 32'h8C00, 3, 12, 1);
    // zero length
    run_cmd("R8 zero length", 32'h3C00, 32'h9C00, 0, 0, 0);
    run_cmd("R8 zero src loopback", 32'h3C00, 32'h9C00, 0, 7, 1);

    // queue full and overflow
    reg_write(8'h80, 32'h0);
    ack_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      build_exp(32'h5000 + 32'(k * 64), 32'h0, 3, 0, 0);
      push_cmd(32'h5000 + 32'(k * 64), 32'h0, 3, 0);
    end
    reg_read(8'h14, v);
    chk("R1 queue full", 64'(v[31:30]), 64'b10);
    reg_read(8'h0C, v);
    chk("R3 no overflow yet", 64'(v[14]), 64'd0);
    push_cmd(32'h7000, 32'h0, 5, 0);
    reg_read(8'h0C, v);
    chk("R3 overflow flag", 64'(v[14]), 64'd1);
    ack_en = 1'b1;
    wait_idle();
    check_log("R3 R11 in-order discard");
    reg_write(8'h0C, 32'hFFFF_FFFF);

    // idle while empty
    repeat (20) @(negedge clk);
    chk("R11 idle no ops", 64'(op_log.size()), 64'd0);
    chk("R11 idle no request", 64'({mem_req, cfg_valid}), 64'd0);

    // random commands
    for (int k = 0; k < 14; k++) begin
      bit lp;
      int sl, dl;
      lp = 1'($urandom % 2);
      sl = int'($urandom % 20);
      dl = lp ? int'($urandom % 20) : int'($urandom % 4);
      base = int'($urandom % 256);
      run_cmd(lp ? "R6 R7 random loopback" : "R4 R5 random stream",
              32'h4000 + 32'(base * 4) + 32'($urandom % 4),
              32'h10000 + 32'(k * 256) + 32'($urandom % 4), sl, dl, lp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule